// File: doc/BRIEF.md
# Programmable-Order Fractional-N Divide Modulator

This block sits in the feedback path of a fractional-N frequency synthesizer. Once per phase-detector clock it issues an integer divide value. Over a long run that value averages to N + NUM/DEN. Inside is a chain of four modulo-DEN accumulators, and DEN may be any 32-bit value rather than a power of two. The carries of the first k stages pass through an error-cancelling difference network: stage j's carry is differenced j-1 times. The resulting small signed offset is added to N, so quantisation noise is pushed toward high frequency. The order is chosen at run time. Code 0 selects plain integer division, codes 1 to 4 select the modulator orders, and codes 5 to 7 also give integer division.

Configuration arrives through a small write port holding five registers. The seed register is special: every write adds to the value already held rather than replacing it. When seeding is enabled, the held seed becomes the starting residue of the first accumulator, which shifts output phase or moves spurs. Any write restarts the modulator from its initial state. A run bit parks the modulator, which zeroes all state and empties the seed. While parked the output is plain N.

Top module: `mash_modulator`

## Requirements
- R1: After reset the output is 100 and stays 100. Reset leaves N=100, NUM=0, DEN=4294967295, order code 0, run=1 and seed enable=0.
- R2: The write address selects the register:
  - 0: N, taken from data bits 18:0 (higher bits ignored).
  - 1: NUM.
  - 2: DEN.
  - 3: seed.
  - 4: control, with order in bits 2:0, run in bit 3 and seed enable in bit 4.
- R3: Every write restarts the modulator. At the edge after the write the state is loaded and the output equals N. The first modulated value appears one edge later.
- R4: Order code 0, and the reserved codes 5, 6 and 7, give an output equal to N on every cycle whatever NUM is.
- R5: In order 1 with a zero seed, the sum of the first DEN outputs after a restart equals N*DEN + NUM.
- R6: For orders 2, 3 and 4 with a zero seed, take T modulated outputs after a restart, where T is a multiple of DEN. DEN*sum - T*(N*DEN+NUM) then lies within [0, DEN], [-DEN, 2*DEN] and [-3*DEN, 4*DEN] respectively. With NUM=0 the output is exactly N.
- R7: Each output minus N lies within:
  - [0,1] for order 1;
  - [-1,2] for order 2;
  - [-3,4] for order 3;
  - [-7,8] for order 4.
- R8: A seed write adds the written value to the held seed modulo 2^32. With seed enable set, the held seed (reduced once by DEN, valid below 2*DEN) is the first accumulator's starting residue. In order 1 with NUM=1 the first carry then occurs at modulated output number DEN - seed (for seed > 0).
- R9: With seed enable clear, the held seed has no effect: the first carry comes at output DEN. The seed is kept, and it applies once seed enable is set.
- R10: With run=0 the output equals N every cycle, NUM is ignored, the held seed is emptied and seed writes are discarded.
- R11: While NUM < DEN, every accumulator residue stays below DEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-detector clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| div_out | output | 19 | Registered instantaneous divide value |

## Verification
The bench sweeps every order code against every numerator for a 16-step modulus, then a few numerators for 7- and 37-step moduli. It compares each run's output sum to the ideal average plus the boundary band that the difference network allows. A wrong carry threshold or a wrong binomial weight shifts the sum outside that band or pushes single outputs past their range. Treating reserved codes as orders, or dropping the fraction in order 1, breaks the exact sums. Seed tests time the first carry: an overwriting seed register moves the carry from output 3 to output 9; a seed that ignores its enable carries early; and a parked modulator that keeps its seed carries before output 16.

// File: rtl/mash_pkg.sv
`timescale 1ns/1ps
package mash_pkg;
    localparam int N_W     = 19;
    localparam int F_W     = 32;
    localparam int MAX_ORD = 4;
    localparam int ADDR_W  = 3;
    localparam int ORD_W   = 3;
    localparam int OFS_W   = MAX_ORD + 2;

    localparam logic [ADDR_W-1:0] A_INT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_NUM  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DEN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SEED = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;

    localparam int C_RUN_BIT  = 3;
    localparam int C_SEED_BIT = 4;

    localparam logic [N_W-1:0] N_RST = N_W'(100);

    typedef struct packed {
        logic [N_W-1:0]   n;
        logic [F_W-1:0]   num;
        logic [F_W-1:0]   den;
        logic [F_W-1:0]   seed;
        logic [ORD_W-1:0] order;
        logic             run;
        logic             seed_en;
    } cfg_t;

    // Reserved codes fall back to integer division.
    function automatic logic [ORD_W-1:0] eff_order(logic [ORD_W-1:0] o);
        return (int'(o) > MAX_ORD) ? '0 : o;
    endfunction

    function automatic int ofs_lo(logic [ORD_W-1:0] o);
        int e;
        e = int'(eff_order(o));
        return (e == 0) ? 0 : 1 - (1 << (e - 1));
    endfunction

    function automatic int ofs_hi(logic [ORD_W-1:0] o);
        int e;
        e = int'(eff_order(o));
        return (e == 0) ? 0 : (1 << (e - 1));
    endfunction

    function automatic int binom(int n, int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
        return r;
    endfunction
endpackage

// File: rtl/mash_cfg.sv
`timescale 1ns/1ps
module mash_cfg
    import mash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [F_W-1:0]    wr_data,
    output cfg_t              cfg,
    output logic              restart
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.n       <= N_RST;
            cfg.num     <= '0;
            cfg.den     <= '1;
            cfg.seed    <= '0;
            cfg.order   <= '0;
            cfg.run     <= 1'b1;
            cfg.seed_en <= 1'b0;
            restart     <= 1'b1;
        end else begin
            restart <= wr_en;
            if (wr_en) begin
                case (wr_addr)
                    A_INT:  cfg.n    <= wr_data[N_W-1:0];
                    A_NUM:  cfg.num  <= wr_data;
                    A_DEN:  cfg.den  <= wr_data;
                    A_SEED: cfg.seed <= cfg.seed + wr_data;
                    A_CTRL: begin
                        cfg.order   <= wr_data[ORD_W-1:0];
                        cfg.run     <= wr_data[C_RUN_BIT];
                        cfg.seed_en <= wr_data[C_SEED_BIT];
                    end
                    default: ;
                endcase
            end
            // Parked modulator empties the seed and discards seed writes.
            if (!cfg.run) cfg.seed <= '0;
        end
    end

    // R10
    seed_park_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.run |=> cfg.seed == '0);
endmodule

// File: rtl/mash_stage.sv
`timescale 1ns/1ps
module mash_stage
    import mash_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           hold,
    input  logic [F_W-1:0] load_val,
    input  logic [F_W-1:0] add_in,
    input  logic [F_W-1:0] den,
    output logic [F_W-1:0] st_q,
    output logic [F_W-1:0] res,
    output logic           carry
);
    logic [F_W:0]   sum;
    logic [F_W-1:0] dif;

    always_comb begin
        sum   = {1'b0, st_q} + {1'b0, add_in};
        dif   = sum[F_W-1:0] - den;
        carry = (sum >= {1'b0, den});
        res   = carry ? dif : sum[F_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       st_q <= '0;
        else if (hold) st_q <= load_val;
        else           st_q <= res;
    end

    // R11
    residue_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && add_in < den && st_q < den) |=> st_q < den);
endmodule

// File: rtl/mash_ncl.sv
`timescale 1ns/1ps
module mash_ncl
    import mash_pkg::*;
#(
    parameter int ORD = MAX_ORD
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hold,
    input  logic [ORD-1:0]          carry,
    input  logic [ORD_W-1:0]        order,
    output logic signed [OFS_W-1:0] ofs
);
    logic signed [OFS_W-1:0] term [ORD];

    assign term[0] = {{(OFS_W-1){1'b0}}, carry[0]};

    // Stage k carry passes through (1 - z^-1)^(k-1).
    for (genvar k = 2; k <= ORD; k++) begin : g_diff
        logic [k-2:0]            sh_q;
        logic [k-1:0]            win;
        logic signed [OFS_W-1:0] t;

        assign win = {sh_q, carry[k-1]};

        always_ff @(posedge clk) begin
            if (rst || hold) sh_q <= '0;
            else             sh_q <= win[k-2:0];
        end

        always_comb begin
            t = '0;
            for (int j = 0; j < k; j++) begin
                if (win[j]) begin
                    if (j % 2 == 1) t = t - OFS_W'(binom(k - 1, j));
                    else            t = t + OFS_W'(binom(k - 1, j));
                end
            end
        end

        assign term[k-1] = t;
    end

    always_comb begin
        ofs = '0;
        for (int k = 0; k < ORD; k++)
            if (k < int'(eff_order(order))) ofs = ofs + term[k];
    end
endmodule

// File: rtl/mash_modulator.sv
`timescale 1ns/1ps
module mash_modulator
    import mash_pkg::*;
#(
    parameter int ORDERS = MAX_ORD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [F_W-1:0]    wr_data,
    output logic [N_W-1:0]    div_out
);
    cfg_t                    cfg;
    logic                    restart;
    logic                    hold;
    logic [F_W-1:0]          seed_ld;
    logic [F_W-1:0]          add_v  [ORDERS];
    logic [F_W-1:0]          load_v [ORDERS];
    logic [F_W-1:0]          st_v   [ORDERS];
    logic [F_W-1:0]          res_v  [ORDERS];
    logic [ORDERS-1:0]       cy;
    logic signed [OFS_W-1:0] ofs;

    mash_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .restart (restart)
    );

    assign hold    = restart || !cfg.run;
    assign seed_ld = (cfg.seed >= cfg.den) ? cfg.seed - cfg.den : cfg.seed;

    for (genvar k = 0; k < ORDERS; k++) begin : g_acc
        if (k == 0) begin : g_first
            assign add_v[k]  = cfg.num;
            assign load_v[k] = cfg.seed_en ? seed_ld : '0;
        end else begin : g_next
            assign add_v[k]  = res_v[k-1];
            assign load_v[k] = '0;
        end

        mash_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .hold     (hold),
            .load_val (load_v[k]),
            .add_in   (add_v[k]),
            .den      (cfg.den),
            .st_q     (st_v[k]),
            .res      (res_v[k]),
            .carry    (cy[k])
        );
    end

    mash_ncl #(.ORD(ORDERS)) u_ncl (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .carry (cy),
        .order (cfg.order),
        .ofs   (ofs)
    );

    always_ff @(posedge clk) begin
        if (rst)       div_out <= N_RST;
        else if (hold) div_out <= cfg.n;
        else           div_out <= cfg.n + N_W'(ofs);
    end

    logic signed [N_W-1:0] dev;
    assign dev = div_out - cfg.n;

    // R7
    ofs_range_chk: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (int'(dev) >= ofs_lo(cfg.order) && int'(dev) <= ofs_hi(cfg.order)));

    // R4
    int_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_order(cfg.order) == '0 && !wr_en) |=> div_out == cfg.n);

    // R10
    parked_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.run && !wr_en) |=> div_out == cfg.n);
endmodule

// File: tb/test_mash_modulator.sv
`timescale 1ns/1ps
module test_mash_modulator;
    import mash_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [F_W-1:0]    wr_data = '0;
    logic [N_W-1:0]    div_out;

    int n_total  = 0;
    int n_passed = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mash_modulator i_mash_modulator (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .div_out (div_out)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_total++;
        if (ok) n_passed++;
        else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    endtask

    function automatic logic [F_W-1:0] ctrl(int ord, bit run, bit sen);
        return F_W'(ord) | (F_W'(run) << C_RUN_BIT) | (F_W'(sen) << C_SEED_BIT);
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(logic [ADDR_W-1:0] a, logic [F_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_case(int ord, int n, longint num, longint den, int periods);
        longint sum, t_len, err, lo, hi, worst;
        int eo, slo, shi;
        bit rng_ok;
        wr(A_INT, F_W'(n));
        wr(A_NUM, F_W'(num));
        wr(A_DEN, F_W'(den));
        wr(A_CTRL, ctrl(ord, 1'b1, 1'b0));
        @(negedge clk);
        chk(div_out == N_W'(n), "R3", "load cycle output", div_out, n);
        eo  = (ord > MAX_ORD) ? 0 : ord;
        slo = (eo == 0) ? 0 : 1 - (1 << (eo - 1));
        shi = (eo == 0) ? 0 : (1 << (eo - 1));
        t_len = periods * den;
        sum = 0; rng_ok = 1'b1; worst = 0;
        for (longint t = 0; t < t_len; t++) begin
            @(negedge clk);
            sum += longint'(div_out);
            if (longint'(div_out) - n < slo || longint'(div_out) - n > shi) begin
                rng_ok = 1'b0;
                worst = longint'(div_out) - n;
            end
        end
        chk(rng_ok, "R7", $sformatf("offset range order %0d num %0d", ord, num), worst, shi);
        if (eo == 0) begin
            chk(sum == n * t_len, "R4", $sformatf("integer sum code %0d num %0d", ord, num),
                sum, n * t_len);
        end else begin
            err = den * sum - t_len * (n * den + num);
            case (eo)
                1: begin lo = 0;  hi = 0; end
                2: begin lo = 0;  hi = 1; end
                3: begin lo = -1; hi = 2; end
                default: begin lo = -3; hi = 4; end
            endcase
            if (num == 0) begin lo = 0; hi = 0; end
            chk(err >= lo * den && err <= hi * den, (eo == 1) ? "R5" : "R6",
                $sformatf("sum error order %0d num %0d den %0d", ord, num, den), err, 0);
        end
    endtask

    // Returns the index of the first output above n, 0 if none within lim.
    task automatic first_carry(int n, int lim, output int idx);
        idx = 0;
        @(negedge clk);
        for (int k = 1; k <= lim; k++) begin
            @(negedge clk);
            if (idx == 0 && div_out == N_W'(n + 1)) idx = k;
        end
    endtask

    initial begin
        int idx;
        bit all_n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: defaults
        all_n = 1'b1;
        chk(div_out == N_RST, "R1", "output after reset", div_out, 100);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (div_out != N_RST) all_n = 1'b0;
        end
        chk(all_n, "R1", "steady default output", div_out, 100);

        // R2: N field takes bits 18:0 only
        wr(A_INT, 32'hFFF8_0000 | 32'd200);
        @(negedge clk);
        @(negedge clk);
        chk(div_out == N_W'(200), "R2", "N field width", div_out, 200);

        // Exhaustive sweep on a 16-step modulus
        for (int ord = 0; ord < 8; ord++)
            for (int num = 0; num < 16; num++)
                run_case(ord, 100, num, 16, 2);
        // Odd moduli
        for (int ord = 1; ord <= 4; ord++)
            for (int num = 0; num < 7; num++)
                run_case(ord, 300, num, 7, 3);
        for (int ord = 0; ord < 8; ord++) begin
            run_case(ord, 5000, 1, 37, 2);
            run_case(ord, 5000, 18, 37, 2);
            run_case(ord, 5000, 36, 37, 2);
        end

        // Seed tests: order 1, NUM=1, DEN=16
        wr(A_INT, 100);
        wr(A_NUM, 1);
        wr(A_DEN, 16);
        wr(A_CTRL, ctrl(1, 1'b0, 1'b0));
        wr(A_CTRL, ctrl(1, 1'b1, 1'b1));
        wr(A_SEED, 6);
        wr(A_SEED, 7);
        first_carry(100, 20, idx);
        chk(idx == 3, "R8", "additive seed 6+7 first carry", idx, 3);

        // R10: park, seed write discarded, NUM ignored
        wr(A_NUM, 5);
        wr(A_CTRL, ctrl(1, 1'b0, 1'b1));
        all_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (div_out != N_W'(100)) all_n = 1'b0;
        end
        chk(all_n, "R10", "parked output equals N", div_out, 100);
        wr(A_SEED, 10);
        wr(A_NUM, 1);
        wr(A_CTRL, ctrl(1, 1'b1, 1'b1));
        first_carry(100, 20, idx);
        chk(idx == 16, "R10", "seed emptied by park", idx, 16);

        // R8: wrap modulo 2^32
        wr(A_SEED, 32'hFFFF_FFF0);
        wr(A_SEED, 32'h0000_0019);
        first_carry(100, 20, idx);
        chk(idx == 7, "R8", "seed wraps mod 2^32", idx, 7);

        // R9: seed enable clear ignores held seed, keeps it
        wr(A_CTRL, ctrl(1, 1'b0, 1'b0));
        wr(A_CTRL, ctrl(1, 1'b1, 1'b0));
        wr(A_SEED, 13);
        first_carry(100, 20, idx);
        chk(idx == 16, "R9", "seed disabled", idx, 16);
        wr(A_CTRL, ctrl(1, 1'b1, 1'b1));
        first_carry(100, 20, idx);
        chk(idx == 3, "R9", "kept seed applied on enable", idx, 3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_passed, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_passed, n_total);
            $finish;
        end
    end
endmodule